// File: doc/BRIEF.md
# Pseudorandom Self-Test Wrapper with Signature Verdict

This block wraps a small combinational circuit under test (CUT) so that the circuit can test itself. In normal operation the CUT input pins carry the primary inputs. While the self-test enable is high, a multiplexer feeds the CUT from a 3-stage linear feedback shift register (LFSR) instead. That register walks through every nonzero state of its maximal-length cycle. The CUT's responses are folded, one pattern per clock, into a multiple-input signature register (MISR).

A single sequencer starts a run on a rising self-test enable. At that point it reloads the generator seed and clears the signature register. It then applies exactly 2^W-1 patterns, where W is the register width. After that it compares the signature with a constant given as a parameter and raises a fail flag on a mismatch. The expected signature is worked out outside the block. A faulty CUT can still alias to the good signature, with a probability of about 2^-W.

The CUT response always reaches the primary outputs. The verdict stays visible until the self-test enable is dropped.

Top module: `selftest_wrap`

## Requirements
- R1: After a run starts, the CUT inputs carry generator states in this order, written as bits [2:0]: 111, 110, 101, 010, 100, 001, 011. The generator shifts towards the MSB, and the new LSB is bit[2] XOR bit[0]. This is the default W=3 with polynomial x^3+x+1 and seed 111. The generator never holds the all-zero state.
- R2: While test_en is low, cut_in equals pi. While test_en is high, cut_in equals the generator state.
- R3: po always equals cut_resp.
- R4: A run applies exactly 2^W-1 patterns, one per clock. done is high for exactly one cycle: the cycle after the last pattern was absorbed.
- R5: sig_fail is 0 when the final signature equals EXP_SIG and 1 otherwise. It is valid in the done cycle and holds while test_en stays high. It returns to 0 one cycle after test_en is sampled low.
- R6: The signature register starts each run at zero. Each pattern cycle it shifts towards the MSB, takes bit[2] XOR bit[0] into the LSB, and XORs in the CUT response bitwise.
- R7: Dropping test_en before the run completes returns the block to idle without a done pulse. The next rise of test_en restarts from the seed with a cleared signature.
- R8: While test_en stays high after a run has completed, no new run starts and done stays low.
- R9: During and after reset, done and sig_fail are low and cut_in equals pi.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| test_en | input | 1 | Self-test enable; a rising level starts a run |
| pi | input | W | Primary inputs for normal operation |
| po | output | W | Primary outputs, driven from the CUT response |
| cut_in | output | W | Drive to the CUT inputs (primary inputs or generator) |
| cut_resp | input | W | Response returned by the CUT |
| done | output | 1 | One-cycle pulse at the end of a complete run |
| sig_fail | output | 1 | High when the final signature mismatched |

## Verification
Counting from the clock edge that samples test_en high, the first generator pattern is on cut_in right after that edge. Each following pattern comes one edge later. done and the verdict appear right after the edge that absorbs the seventh pattern, which is the eighth edge overall. The fail flag clears one edge after test_en is sampled low.

A monitor samples shortly after each rising edge and pops the expected pattern that the run task queued before raising test_en. The run task itself checks done and sig_fail on the falling edge that follows the eighth edge. The multiplexer and the primary-output path are combinational, so they are checked in the same cycle as their stimulus. The expected signatures for the good CUT model and a stuck-at model are computed in the bench from the update rule.

// File: rtl/lbist_pkg.sv
package lbist_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2,
    ST_HOLD = 2'd3
  } seq_state_e;
endpackage

// File: rtl/lbist_rst_sync.sv
module lbist_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/lbist_lfsr.sv
module lbist_lfsr #(
  parameter int          W    = 3,
  parameter logic [W-1:0] TAPS = 3'b101,
  parameter logic [W-1:0] SEED = 3'b111
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         adv,
  output logic [W-1:0] q
);
  logic [W-1:0] q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (load)     q_d = SEED;
    else if (adv) q_d = {q_q[W-2:0], ^(q_q & TAPS)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= SEED;
    else        q_q <= q_d;
  end

  assign q = q_q;

  // R1: generator never locks in the all-zero state
  a_r1_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
    q_q != '0);

  // R7: a run start always reloads the seed
  a_r7_seed_reload: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q_q == SEED));
endmodule

// File: rtl/lbist_misr.sv
module lbist_misr #(
  parameter int           W    = 3,
  parameter logic [W-1:0] TAPS = 3'b101
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] resp,
  output logic [W-1:0] sig_nxt,
  output logic [W-1:0] sig
);
  logic [W-1:0] sig_q, sig_d;

  assign sig_nxt = {sig_q[W-2:0], ^(sig_q & TAPS)} ^ resp;

  always_comb begin
    sig_d = sig_q;
    if (clr)     sig_d = '0;
    else if (en) sig_d = sig_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= '0;
    else        sig_q <= sig_d;
  end

  assign sig = sig_q;

  // R6: every run begins with an empty signature
  a_r6_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sig_q == '0));
endmodule

// File: rtl/lbist_seq.sv
module lbist_seq
  import lbist_pkg::*;
#(
  parameter int           W       = 3,
  parameter int           RUN_LEN = 7,
  parameter logic [W-1:0] EXP_SIG = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         test_en,
  input  logic [W-1:0] sig_nxt,
  output logic         load,
  output logic         clr,
  output logic         step,
  output logic         done,
  output logic         fail
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

  seq_state_e   st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          fail_q, fail_d;
  logic          capture, verdict_clr;

  always_comb begin
    st_d        = st_q;
    cnt_d       = cnt_q;
    load        = 1'b0;
    clr         = 1'b0;
    step        = 1'b0;
    capture     = 1'b0;
    verdict_clr = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (test_en) begin
          st_d        = ST_RUN;
          load        = 1'b1;
          clr         = 1'b1;
          verdict_clr = 1'b1;
          cnt_d       = '0;
        end
      end
      ST_RUN: begin
        if (!test_en) begin
          st_d = ST_IDLE;
        end else begin
          step  = 1'b1;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            st_d    = ST_DONE;
            capture = 1'b1;
          end
        end
      end
      ST_DONE: begin
        if (!test_en) begin
          st_d        = ST_IDLE;
          verdict_clr = 1'b1;
        end else begin
          st_d = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (!test_en) begin
          st_d        = ST_IDLE;
          verdict_clr = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    fail_d = fail_q;
    if (verdict_clr)  fail_d = 1'b0;
    else if (capture) fail_d = (sig_nxt != EXP_SIG);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      fail_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      fail_q <= fail_d;
    end
  end

  assign done = (st_q == ST_DONE);
  assign fail = fail_q;

  // R4: done is a single-cycle pulse
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4: done follows exactly RUN_LEN stepping cycles
  a_r4_run_length: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(cnt_q) == LAST));

  // R5: the verdict can only rise together with done
  a_r5_fail_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_q) |-> done);

  // R5: a low enable clears the verdict on the next cycle
  a_r5_fail_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en |=> !fail_q);
endmodule

// File: rtl/selftest_wrap.sv
module selftest_wrap #(
  parameter int           W       = 3,
  parameter logic [W-1:0] TAPS    = 3'b101,
  parameter logic [W-1:0] SEED    = 3'b111,
  parameter logic [W-1:0] EXP_SIG = 3'b000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         test_en,
  input  logic [W-1:0] pi,
  output logic [W-1:0] po,
  output logic [W-1:0] cut_in,
  input  logic [W-1:0] cut_resp,
  output logic         done,
  output logic         sig_fail
);
  localparam int RUN_LEN = (2 ** W) - 1;

  logic         rst_n_i;
  logic         load, clr, step;
  logic [W-1:0] pattern, sig_nxt, sig_unused;

  lbist_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  lbist_lfsr #(.W(W), .TAPS(TAPS), .SEED(SEED)) u_gen (
    .clk   (clk),
    .rst_n (rst_n_i),
    .load  (load),
    .adv   (step),
    .q     (pattern)
  );

  lbist_misr #(.W(W), .TAPS(TAPS)) u_cmp (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .clr     (clr),
    .en      (step),
    .resp    (cut_resp),
    .sig_nxt (sig_nxt),
    .sig     (sig_unused)
  );

  lbist_seq #(.W(W), .RUN_LEN(RUN_LEN), .EXP_SIG(EXP_SIG)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .test_en (test_en),
    .sig_nxt (sig_nxt),
    .load    (load),
    .clr     (clr),
    .step    (step),
    .done    (done),
    .fail    (sig_fail)
  );

  assign cut_in = test_en ? pattern : pi;
  assign po     = cut_resp;

  // R9: nothing reports a result while reset is active
  a_r9_quiet_reset: assert property (@(posedge clk)
    !rst_n_i |-> (!done && !sig_fail));
endmodule

// File: tb/selftest_wrap_tb_top.sv
`timescale 1ns/1ps
module selftest_wrap_tb_top;
  localparam int W = 3;

  function automatic logic [2:0] cut_fn(input logic [2:0] c, input logic flt);
    logic [2:0] r;
    r = {c[2] ^ c[0], c[1] & c[2], c[0] | c[1]};
    if (flt) r[1] = 1'b1;
    return r;
  endfunction

  function automatic logic [2:0] calc_sig(input logic flt);
    logic [2:0] m, g;
    m = 3'b000;
    g = 3'b111;
    for (int i = 0; i < 7; i++) begin
      m = {m[1:0], m[2] ^ m[0]} ^ cut_fn(g, flt);
      g = {g[1:0], g[2] ^ g[0]};
    end
    return m;
  endfunction

  localparam logic [2:0] GOOD_SIG = calc_sig(1'b0);
  localparam logic [2:0] BAD_SIG  = calc_sig(1'b1);

  logic       clk = 1'b0;
  logic       rst_n, test_en, fault;
  logic [2:0] pi, po, cut_in, cut_resp;
  logic       done, sig_fail;
  logic [2:0] exp_q[$];
  int         n_chk = 0, n_bad = 0;
  bit         finished = 0;

  always #2.5 clk = ~clk;

  assign cut_resp = cut_fn(cut_in, fault);

  selftest_wrap #(.W(W), .TAPS(3'b101), .SEED(3'b111), .EXP_SIG(GOOD_SIG)) dut_i (
    .clk(clk), .rst_n(rst_n), .test_en(test_en), .pi(pi), .po(po),
    .cut_in(cut_in), .cut_resp(cut_resp), .done(done), .sig_fail(sig_fail)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected generator patterns just after each rising edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [2:0] e;
      e = exp_q.pop_front();
      check("R1 pattern", {5'b0, cut_in}, {5'b0, e});
      check("R2 mux to generator", {7'b0, test_en}, 8'd1);
    end
  end

  task automatic push_patterns(input int n);
    logic [2:0] g;
    g = 3'b111;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(g);
      g = {g[1:0], g[2] ^ g[0]};
    end
  endtask

  task automatic run_full(input logic flt);
    logic exp_fail;
    exp_fail = flt ? (BAD_SIG != GOOD_SIG) : 1'b0;
    @(negedge clk);
    fault = flt;
    push_patterns(7);
    test_en = 1'b1;
    repeat (7) begin
      @(negedge clk);
      check("R4 no early done", {7'b0, done}, 8'd0);
    end
    @(negedge clk);
    check("R4 done pulse", {7'b0, done}, 8'd1);
    check("R5 verdict", {7'b0, sig_fail}, {7'b0, exp_fail});
    check("R1 all patterns applied", exp_q.size(), 8'd0);
    repeat (3) begin
      @(negedge clk);
      check("R8 no rerun", {7'b0, done}, 8'd0);
      check("R5 verdict held", {7'b0, sig_fail}, {7'b0, exp_fail});
    end
    test_en = 1'b0;
    @(negedge clk);
    check("R5 verdict cleared", {7'b0, sig_fail}, 8'd0);
    check("R2 mux to pi", {5'b0, cut_in}, {5'b0, pi});
    fault = 1'b0;
  endtask

  task automatic finish_up;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_up();
  end

  initial begin
    rst_n = 1'b0;
    test_en = 1'b0;
    fault = 1'b0;
    pi = 3'b101;
    repeat (3) @(negedge clk);
    check("R9 done in reset", {7'b0, done}, 8'd0);
    check("R9 fail in reset", {7'b0, sig_fail}, 8'd0);
    check("R9 cut_in is pi", {5'b0, cut_in}, 8'h05);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    pi = 3'b010;
    #1;
    check("R2 pi pass", {5'b0, cut_in}, 8'h02);
    check("R3 po follows response", {5'b0, po}, {5'b0, cut_fn(3'b010, 1'b0)});

    run_full(1'b0);
    run_full(1'b1);

    // abort after three patterns
    @(negedge clk);
    push_patterns(3);
    test_en = 1'b1;
    repeat (3) @(negedge clk);
    test_en = 1'b0;
    repeat (10) begin
      @(negedge clk);
      check("R7 abort no done", {7'b0, done}, 8'd0);
    end
    check("R7 abort fail low", {7'b0, sig_fail}, 8'd0);
    // restart must reseed and clear the signature (R7, R6)
    run_full(1'b0);
    pi = 3'b111;
    #1;
    check("R3 po after runs", {5'b0, po}, {5'b0, cut_fn(3'b111, 1'b0)});
    finish_up();
  end
endmodule